// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block stamps external events with the value of a free-running 16-bit counter. One of two event inputs is selected, brought into the clock domain by a synchronizer, optionally cleaned by a noise filter, and watched for a programmable edge. Each qualified edge copies the counter into a capture register and raises a capture interrupt request. Software then reads the stamp over an 8-bit register bus.

The capture register has no storage of its own. It reuses two 8-bit compare registers, A and B. In 8-bit capture mode, only compare-A takes the stamp, and compare-B stays a live compare register whose match output is active. In 16-bit capture mode, compare-A takes the low byte of the stamp and compare-B takes the high byte. A shared holding byte makes 16-bit reads of both the counter and the capture atomic. A counter overflow flag gives a second interrupt request.

Register addresses:
- 0: control. Bit 0 selects the source (0 = input 0, 1 = input 1). Bit 1 enables the filter. Bit 2 selects the edge (1 = rising, 0 = falling). Bit 3 selects 16-bit mode.
- 1: flags. Bit 0 is the capture flag and bit 1 is the overflow flag. Writing 1 to a bit clears it.
- 2: counter low byte.
- 3: counter high byte.
- 4: compare-A, which is also the capture low byte.
- 5: compare-B, which is also the capture high byte.

Top module: `evt_capture_timer`

## Requirements
- R1: After reset, the control, flags, compare-A and compare-B registers all read 0, and both interrupt outputs are low.
- R2: The counter advances by one every clock. A read of address 2 returns the counter low byte and, in the same access, copies the counter high byte into the holding byte. A read of address 3 returns the holding byte. The two reads therefore give a consistent 16-bit value even when a carry into the high byte happens between them.
- R3: Flags bit 1 and `irq_ovf_o` go high on the clock edge at which the counter rolls from 0xFFFF to 0x0000. Writing 0x02 to address 1 clears them.
- R4: Only the input chosen by control bit 0 can trigger a capture. Edges on the other input have no effect.
- R5: With control bit 2 = 1, only rising edges capture. With control bit 2 = 0, only falling edges capture.
- R6: With the filter off, an input change driven while the counter holds N captures the value N+2.
- R7: With the filter on (control bit 1), a new level is accepted only after 4 consecutive identical samples. A pulse 3 samples long is ignored. An accepted change captures N+6.
- R8: In 8-bit mode, a capture loads only the counter low byte, into compare-A. Compare-B keeps the value software wrote.
- R9: In 16-bit mode, one capture loads the low byte into compare-A and the high byte into compare-B. A read of address 4 copies compare-B into the holding byte, and a read of address 5 then returns the holding byte.
- R10: Each capture sets flags bit 0 and `irq_capt_o`. Writing 0 to that bit leaves it set, and writing 1 clears it. A capture while the flag is already set overwrites the stored stamp.
- R11: `cmp_b_match_o` is high while the counter low byte equals compare-B, and only in 8-bit mode. It is always low in 16-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt0_i | input | 1 | Event input 0 (asynchronous) |
| evt1_i | input | 1 | Event input 1 (asynchronous) |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (drives read side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational from address) |
| irq_capt_o | output | 1 | Capture interrupt request |
| irq_ovf_o | output | 1 | Counter overflow interrupt request |
| cmp_b_match_o | output | 1 | Compare-B match, 8-bit mode only |

## Verification
The hardest state to reach from the ports is the counter wrap. Reaching it takes 65,536 clocks, so that scenario runs last and waits until the bench's own cycle count reaches 0xFFFF before it samples the flag on either side of the roll. The carry case for atomic reads is also hard to hit. The bench starts the low-byte read exactly when the low byte is 0xFF, so a live high-byte read would return the wrong value. Filter rejection is reached by holding an input for exactly three cycles between two negative edges, one sample short of acceptance.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_L = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_H = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP_L = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAP_H = 3'd5;

  typedef struct packed {
    logic mode16;
    logic edge_rise;
    logic nc_en;
    logic src_sel;
  } cap_ctrl_t;
endpackage

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + W'(1);
  end

  // high in the cycle whose closing edge rolls the counter to zero
  assign wrap_o = &cnt_o;
endmodule

// File: rtl/cap_evt_path.sv
module cap_evt_path #(
  parameter int N_SRC    = 2,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [$clog2(N_SRC)-1:0] src_sel_i,
  input  logic             nc_en_i,
  input  logic             edge_rise_i,
  output logic             capt_o
);
  localparam int HIST_W = FILT_LEN - 1;

  logic [N_SRC-1:0] evt_s;

  for (genvar g = 0; g < N_SRC; g++) begin : g_sync
    logic [SYNC_LEN-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[SYNC_LEN-2:0], evt_i[g]};
    end
    assign evt_s[g] = sh_q[SYNC_LEN-1];
  end

  logic              sel_lvl;
  logic [HIST_W-1:0] hist_q;
  logic              filt_q;
  logic              lvl;
  logic              prev_q;
  logic              all_hi;
  logic              all_lo;

  assign sel_lvl = evt_s[src_sel_i];

  // FILT_LEN samples: current synchronized level plus HIST_W older ones
  assign all_hi = sel_lvl & (&hist_q);
  assign all_lo = ~sel_lvl & ~(|hist_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[HIST_W-2:0], sel_lvl};
      if (all_hi)      filt_q <= 1'b1;
      else if (all_lo) filt_q <= 1'b0;
    end
  end

  assign lvl = nc_en_i ? filt_q : sel_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  assign capt_o = edge_rise_i ? (lvl & ~prev_q) : (~lvl & prev_q);
endmodule

// File: rtl/cap_regs.sv
module cap_regs
  import cap_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              capt_i,
  input  logic              wrap_i,
  output cap_ctrl_t         ctrl_o,
  output logic [BUS_W-1:0]  ocr_a_o,
  output logic [BUS_W-1:0]  ocr_b_o,
  output logic              capt_flag_o,
  output logic              ovf_flag_o
);
  logic [BUS_W-1:0] temp_q;
  logic wr_ctrl, wr_flags, wr_a, wr_b, rd_cnt_l, rd_cap_l;

  assign wr_ctrl  = wr_en_i && addr_i == A_CTRL;
  assign wr_flags = wr_en_i && addr_i == A_FLAGS;
  assign wr_a     = wr_en_i && addr_i == A_CAP_L;
  assign wr_b     = wr_en_i && addr_i == A_CAP_H;
  assign rd_cnt_l = rd_en_i && addr_i == A_CNT_L;
  assign rd_cap_l = rd_en_i && addr_i == A_CAP_L;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o      <= '0;
      ocr_a_o     <= '0;
      ocr_b_o     <= '0;
      temp_q      <= '0;
      capt_flag_o <= 1'b0;
      ovf_flag_o  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_o <= cap_ctrl_t'(wdata_i[$bits(cap_ctrl_t)-1:0]);
      // capture has priority over a bus write to the same byte
      if (capt_i)    ocr_a_o <= cnt_i[BUS_W-1:0];
      else if (wr_a) ocr_a_o <= wdata_i;
      if (capt_i && ctrl_o.mode16) ocr_b_o <= cnt_i[CNT_W-1:BUS_W];
      else if (wr_b)               ocr_b_o <= wdata_i;
      if (rd_cnt_l)                      temp_q <= cnt_i[CNT_W-1:BUS_W];
      else if (rd_cap_l && ctrl_o.mode16) temp_q <= ocr_b_o;
      // set wins over write-1-clear
      if (capt_i)                      capt_flag_o <= 1'b1;
      else if (wr_flags && wdata_i[0]) capt_flag_o <= 1'b0;
      if (wrap_i)                      ovf_flag_o <= 1'b1;
      else if (wr_flags && wdata_i[1]) ovf_flag_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[$bits(cap_ctrl_t)-1:0] = ctrl_o;
      A_FLAGS: rdata_o[1:0] = {ovf_flag_o, capt_flag_o};
      A_CNT_L: rdata_o = cnt_i[BUS_W-1:0];
      A_CNT_H: rdata_o = temp_q;
      A_CAP_L: rdata_o = ocr_a_o;
      A_CAP_H: rdata_o = ctrl_o.mode16 ? temp_q : ocr_b_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_capture_timer.sv
module evt_capture_timer
  import cap_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt0_i,
  input  logic              evt1_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_capt_o,
  output logic              irq_ovf_o,
  output logic              cmp_b_match_o
);
  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] cnt_w;
  logic             wrap_w;
  logic             capt_w;
  cap_ctrl_t        ctrl_w;
  logic [BUS_W-1:0] ocr_a_w;
  logic [BUS_W-1:0] ocr_b_w;
  logic             capt_flag_w;
  logic             ovf_flag_w;

  cap_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_w)
  );

  cap_evt_path #(
    .N_SRC    (2),
    .SYNC_LEN (SYNC_LEN),
    .FILT_LEN (FILT_LEN)
  ) u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       ({evt1_i, evt0_i}),
    .src_sel_i   (ctrl_w.src_sel),
    .nc_en_i     (ctrl_w.nc_en),
    .edge_rise_i (ctrl_w.edge_rise),
    .capt_o      (capt_w)
  );

  cap_regs #(.BUS_W(BUS_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .cnt_i       (cnt_w),
    .capt_i      (capt_w),
    .wrap_i      (wrap_w),
    .ctrl_o      (ctrl_w),
    .ocr_a_o     (ocr_a_w),
    .ocr_b_o     (ocr_b_w),
    .capt_flag_o (capt_flag_w),
    .ovf_flag_o  (ovf_flag_w)
  );

  assign irq_capt_o    = capt_flag_w;
  assign irq_ovf_o     = ovf_flag_w;
  assign cmp_b_match_o = ~ctrl_w.mode16 && (cnt_w[BUS_W-1:0] == ocr_b_w);
endmodule

// File: rtl/evt_capture_timer_chk.sv
module evt_capture_timer_chk
  import cap_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              capt_i,
  input logic              mode16_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [BUS_W-1:0]  ocr_a_i,
  input logic [BUS_W-1:0]  ocr_b_i,
  input logic              capt_flag_i,
  input logic              ovf_flag_i,
  input logic              cmp_b_match_i
);
  logic wr_b;
  assign wr_b = wr_en_i && addr_i == A_CAP_H;

  a_r2_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_i == CNT_W'($past(cnt_i) + CNT_W'(1)));

  a_r3_ovf_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_i) |=> (ovf_flag_i && cnt_i == '0));

  a_r8_ocrb_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capt_i && !mode16_i && !wr_b) |=> ocr_b_i == $past(ocr_b_i));

  a_r9_capt_16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capt_i && mode16_i) |=> {ocr_b_i, ocr_a_i} == $past(cnt_i));

  a_r10_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capt_i |=> capt_flag_i);

  a_r11_cmpb_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode16_i |-> !cmp_b_match_i);
endmodule

bind evt_capture_timer evt_capture_timer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wr_en_i       (wr_en_i),
  .capt_i        (capt_w),
  .mode16_i      (ctrl_w.mode16),
  .cnt_i         (cnt_w),
  .ocr_a_i       (ocr_a_w),
  .ocr_b_i       (ocr_b_w),
  .capt_flag_i   (capt_flag_w),
  .ovf_flag_i    (ovf_flag_w),
  .cmp_b_match_i (cmp_b_match_o)
);

// File: tb/evt_capture_timer_tb_top.sv
module evt_capture_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt0 = 1'b0, evt1 = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_capt, irq_ovf, cmp_b_match;
  logic [15:0] cyc;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // reference time base: edges since reset release
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 16'd1;

  evt_capture_timer dut_i (
    .clk_i (clk), .rst_ni (rst_n), .evt0_i (evt0), .evt1_i (evt1),
    .addr_i (addr), .wr_en_i (wr_en), .rd_en_i (rd_en), .wdata_i (wdata),
    .rdata_o (rdata), .irq_capt_o (irq_capt), .irq_ovf_o (irq_ovf),
    .cmp_b_match_o (cmp_b_match)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // accesses start and end at a negedge, one cycle each
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd1, d); chk("R1 flags", d, 0);
    rd(3'd4, d); chk("R1 cmp_a", d, 0);
    rd(3'd5, d); chk("R1 cmp_b", d, 0);
    chk("R1 irqs", {irq_capt, irq_ovf}, 0);
  endtask

  task automatic t_counter;
    logic [7:0] lo, hi;
    while (cyc != 16'h01FF) @(negedge clk);
    rd(3'd2, lo);
    rd(3'd3, hi);
    chk("R2 atomic count read", {hi, lo}, 16'h01FF);
  endtask

  task automatic t_mode8;
    logic [7:0] d;
    logic [15:0] n;
    wr(3'd0, 8'h04);
    wr(3'd5, 8'hA5);
    n = cyc; evt0 = 1'b1;
    idle(8);
    rd(3'd4, d); chk("R6/R8 cmp_a stamp", d, 8'(n + 16'd2));
    rd(3'd5, d); chk("R8 cmp_b kept", d, 8'hA5);
    rd(3'd1, d); chk("R10 flag set", d, 8'h01);
    chk("R10 irq", irq_capt, 1'b1);
    wr(3'd1, 8'h01);
    evt0 = 1'b0; idle(8);
    rd(3'd1, d); chk("R5 falling ignored in rising mode", d, 0);
  endtask

  task automatic t_mode16;
    logic [7:0] lo, hi;
    logic [15:0] n;
    wr(3'd0, 8'h0C);
    idle(300);
    n = cyc; evt0 = 1'b1;
    idle(8);
    rd(3'd4, lo);
    rd(3'd5, hi);
    chk("R9 16-bit stamp", {hi, lo}, n + 16'd2);
    evt0 = 1'b0; wr(3'd1, 8'h01);
    idle(4);
  endtask

  task automatic t_filter;
    logic [7:0] d;
    logic [15:0] n;
    wr(3'd0, 8'h06);
    idle(6);
    evt0 = 1'b1; idle(3); evt0 = 1'b0;
    idle(12);
    rd(3'd1, d); chk("R7 short pulse rejected", d, 0);
    n = cyc; evt0 = 1'b1;
    idle(12);
    rd(3'd4, d); chk("R7 filtered stamp", d, 8'(n + 16'd6));
    rd(3'd1, d); chk("R7 flag after accept", d, 8'h01);
    evt0 = 1'b0; idle(12);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h04);
    idle(4);
  endtask

  task automatic t_source;
    logic [7:0] d;
    logic [15:0] n;
    evt1 = 1'b1; idle(8);
    rd(3'd1, d); chk("R4 unselected input ignored", d, 0);
    evt1 = 1'b0; idle(8);
    wr(3'd0, 8'h05);
    idle(4);
    n = cyc; evt1 = 1'b1;
    idle(8);
    rd(3'd4, d); chk("R4 input 1 stamp", d, 8'(n + 16'd2));
    wr(3'd1, 8'h01);
    evt1 = 1'b0; idle(8);
    wr(3'd0, 8'h04);
    idle(4);
  endtask

  task automatic t_falling;
    logic [7:0] d;
    logic [15:0] n;
    wr(3'd0, 8'h00);
    evt0 = 1'b1; idle(8);
    rd(3'd1, d); chk("R5 rising ignored in falling mode", d, 0);
    n = cyc; evt0 = 1'b0;
    idle(8);
    rd(3'd4, d); chk("R5 falling stamp", d, 8'(n + 16'd2));
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h04);
    idle(4);
  endtask

  task automatic t_overwrite;
    logic [7:0] d;
    logic [15:0] n;
    evt0 = 1'b1; idle(6); evt0 = 1'b0; idle(6);
    n = cyc; evt0 = 1'b1;
    idle(8);
    rd(3'd4, d); chk("R10 overwrite while set", d, 8'(n + 16'd2));
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk("R10 write 0 keeps flag", d, 8'h01);
    wr(3'd1, 8'h01);
    rd(3'd1, d); chk("R10 write 1 clears flag", d, 0);
    chk("R10 irq cleared", irq_capt, 1'b0);
    evt0 = 1'b0; idle(6);
  endtask

  task automatic t_cmpb;
    wr(3'd0, 8'h04);
    wr(3'd5, 8'h40);
    while (cyc[7:0] != 8'h40) @(negedge clk);
    #1 chk("R11 match in 8-bit", cmp_b_match, 1'b1);
    @(negedge clk);
    #1 chk("R11 match drops", cmp_b_match, 1'b0);
    @(negedge clk);
    wr(3'd0, 8'h0C);
    while (cyc[7:0] != 8'h40) @(negedge clk);
    #1 chk("R11 no match in 16-bit", cmp_b_match, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_ovf;
    logic [7:0] d;
    while (cyc != 16'hFFFF) @(negedge clk);
    rd(3'd1, d); chk("R3 no ovf before wrap", d[1], 1'b0);
    #1 chk("R3 ovf at wrap", irq_ovf, 1'b1);
    rd(3'd1, d); chk("R3 ovf flag bit", d[1], 1'b1);
    wr(3'd1, 8'h02);
    #1 chk("R3 ovf cleared", irq_ovf, 1'b0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_counter;
    t_mode8;
    t_mode16;
    t_filter;
    t_source;
    t_falling;
    t_overwrite;
    t_cmpb;
    t_ovf;
    done = 1;
    summary;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary;
    end
  end
endmodule